// File: doc/BRIEF.md
# Audio Source-Destination Crossbar

This block routes sample streams between four audio sources and four audio sinks. The sources are DMA playback (code 00), DSP transmit (code 01), external input (code 10) and the A/D converter (code 11). The sinks are DMA record, DSP receive, external output and the D/A converter. Each sink picks its source on its own, and one source can feed any number of sinks at the same time.

Every sink has a handshake switch. With the handshake on, a sample moves when the chosen source asserts valid and the sink asserts ready. With the handshake off, the sink sees valid on each sample strobe of its source, and its own ready has no effect. A source's ready is the AND of the ready signals of all connected, handshaking sinks that select it. Ready never depends on any valid.

Each source also carries a clock selection, which the block cleans up and outputs. A link bit in the DSP fields detaches the DSP transmit side and the DSP receive side from the matrix, so that an external serial port can use those pins. Software programs the block through four byte-wide registers.

Top module: `audio_xbar`

## Requirements
- R1: After reset both configuration words are zero. Every sink then selects DMA playback with the handshake on, both DSP links are detached, `dsp_rx_oe` is 0 and `src_clk_sel` is 0.
- R2: A write with `cfg_addr` 0, 1, 2 or 3 loads, in that order, the low byte of the source word, the high byte of the source word, the low byte of the sink word and the high byte of the sink word. The new value takes effect from the clock edge that accepts the write. Field i of each word is at bits 4i+3:4i, with bit 0 = handshake off, bits 2:1 = code and bit 3 = link (used in field 1 only).
- R3: A sink with the handshake on and a connected path shows `dst_valid` equal to `src_valid` of its selected source, and `dst_data` equal to that source's data.
- R4: A sink with the handshake off shows `dst_valid` equal to `src_stb` of its selected source. Its `dst_ready` does not enter any `src_ready`.
- R5: `src_ready[s]` is the AND of `dst_ready` over all connected, handshaking sinks that select s. It is 1 when no such sink exists.
- R6: A source whose own field has bit 0 set drives `src_ready` = 1 (the DSP transmit source only while attached).
- R7: While source field 1 bit 3 is 0, every sink that selects code 01 shows valid 0 and data 0, and `src_ready[1]` is 0.
- R8: While sink field 1 bit 3 is 0, `dsp_rx_oe` is 0, `dst_valid[1]` is 0, sink 1's data is 0, and `dst_ready[1]` is excluded from every `src_ready`.
- R9: `src_clk_sel` field s (bits 2s+1:2s) copies the clock code of source field s (00 internal 25.175 MHz, 01 external, 10 internal 32 MHz). Code 11 becomes 00. Code 10 on the A/D converter (s = 3) becomes 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Byte select: 0/1 source word lo/hi, 2/3 sink word lo/hi |
| cfg_wdata | input | 8 | Configuration byte |
| src_valid | input | 4 | Per-source valid, indexed by source code |
| src_stb | input | 4 | Per-source sample strobe |
| src_data | input | 4*DW | Per-source sample, source s at bits DW*s+DW-1:DW*s |
| src_ready | output | 4 | Per-source ready |
| dst_valid | output | 4 | Per-sink valid (0 DMA rec, 1 DSP rx, 2 ext out, 3 D/A) |
| dst_data | output | 4*DW | Per-sink sample, sink d at bits DW*d+DW-1:DW*d |
| dst_ready | input | 4 | Per-sink ready |
| dsp_rx_oe | output | 1 | DSP receive output enable (0 = tri-state) |
| src_clk_sel | output | 8 | Clean clock code per source, 2 bits each |

## Verification
A configuration write can change a sink's source selector in the same cycle that the old source is presenting a valid sample. The bench provokes this by holding valid, with different data, on both the old source and the new source while the write strobe is high across a clock edge. Before that edge the sink must still show the old source's data. After the edge it must show the new source's data, with no cycle that mixes the two.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NDEV    = 4;
  localparam int DSP_IDX = 1;
  localparam int ADC_IDX = 3;

  typedef enum logic [1:0] {
    SRC_DMA_PLAY = 2'b00,
    SRC_DSP_TX   = 2'b01,
    SRC_EXT_IN   = 2'b10,
    SRC_ADC      = 2'b11
  } src_code_e;

  typedef enum logic [1:0] {
    CLK_INT25 = 2'b00,
    CLK_EXT   = 2'b01,
    CLK_INT32 = 2'b10,
    CLK_UNDEF = 2'b11
  } clk_code_e;

  // bit3 link, bits2:1 code, bit0 handshake off
  typedef struct packed {
    logic       link;
    logic [1:0] code;
    logic       hs_off;
  } dev_field_t;
endpackage

// File: rtl/xbar_cfg.sv
module xbar_cfg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [15:0] src_word,
  output logic [15:0] dst_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_word <= '0;
      dst_word <= '0;
    end else if (we) begin
      case (addr)
        2'd0: src_word[7:0]  <= wdata;
        2'd1: src_word[15:8] <= wdata;
        2'd2: dst_word[7:0]  <= wdata;
        default: dst_word[15:8] <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/xbar_clk.sv
module xbar_clk
  import xbar_pkg::*;
(
  input  dev_field_t [NDEV-1:0] src_f,
  output logic [2*NDEV-1:0]     clk_sel
);
  for (genvar s = 0; s < NDEV; s++) begin : g_clk
    always_comb begin
      clk_sel[2*s +: 2] = src_f[s].code;
      if (src_f[s].code == CLK_UNDEF)
        clk_sel[2*s +: 2] = CLK_INT25;
      if (s == ADC_IDX && src_f[s].code == CLK_INT32)
        clk_sel[2*s +: 2] = CLK_INT25;
    end
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int DW        = 16,
  parameter bit IS_DSP_RX = 1'b0
) (
  input  dev_field_t                 fld,
  input  logic                       tx_link,
  input  logic                       rx_link,
  input  logic [NDEV-1:0]            src_valid,
  input  logic [NDEV-1:0]            src_stb,
  input  logic [NDEV-1:0][DW-1:0]    src_data,
  output logic                       valid,
  output logic [DW-1:0]              data,
  output logic [NDEV-1:0]            want
);
  logic tx_cut, rx_cut;

  always_comb begin
    tx_cut = (fld.code == SRC_DSP_TX) && !tx_link;
    rx_cut = IS_DSP_RX && !rx_link;
    if (tx_cut || rx_cut) begin
      valid = 1'b0;
      data  = '0;
    end else begin
      valid = fld.hs_off ? src_stb[fld.code] : src_valid[fld.code];
      data  = src_data[fld.code];
    end
    want = '0;
    if (!fld.hs_off && !rx_cut)
      want[fld.code] = 1'b1;
  end
endmodule

// File: rtl/xbar_ready.sv
module xbar_ready
  import xbar_pkg::*;
(
  input  logic [NDEV-1:0][NDEV-1:0] want,
  input  logic [NDEV-1:0]           dst_ready,
  input  dev_field_t [NDEV-1:0]     src_f,
  input  logic                      tx_link,
  output logic [NDEV-1:0]           src_ready
);
  for (genvar s = 0; s < NDEV; s++) begin : g_src
    always_comb begin
      logic ok;
      ok = 1'b1;
      for (int d = 0; d < NDEV; d++)
        if (want[d][s] && !dst_ready[d]) ok = 1'b0;
      if (s == DSP_IDX && !tx_link)
        src_ready[s] = 1'b0;
      else if (src_f[s].hs_off)
        src_ready[s] = 1'b1;
      else
        src_ready[s] = ok;
    end
  end
endmodule

// File: rtl/audio_xbar.sv
module audio_xbar
  import xbar_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  input  logic [3:0]         src_valid,
  input  logic [3:0]         src_stb,
  input  logic [4*DW-1:0]    src_data,
  output logic [3:0]         src_ready,
  output logic [3:0]         dst_valid,
  output logic [4*DW-1:0]    dst_data,
  input  logic [3:0]         dst_ready,
  output logic               dsp_rx_oe,
  output logic [7:0]         src_clk_sel
);
  logic [15:0] src_word, dst_word;
  dev_field_t [NDEV-1:0] src_f, dst_f;
  logic tx_link, rx_link;
  logic [NDEV-1:0][DW-1:0]   sdata;
  logic [NDEV-1:0][DW-1:0]   ddata;
  logic [NDEV-1:0][NDEV-1:0] want;

  xbar_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .src_word(src_word), .dst_word(dst_word)
  );

  assign src_f     = src_word;
  assign dst_f     = dst_word;
  assign tx_link   = src_f[DSP_IDX].link;
  assign rx_link   = dst_f[DSP_IDX].link;
  assign dsp_rx_oe = rx_link;
  assign sdata     = src_data;
  assign dst_data  = ddata;

  for (genvar d = 0; d < NDEV; d++) begin : g_dst
    xbar_route #(.DW(DW), .IS_DSP_RX(d == DSP_IDX)) u_route (
      .fld(dst_f[d]), .tx_link(tx_link), .rx_link(rx_link),
      .src_valid(src_valid), .src_stb(src_stb), .src_data(sdata),
      .valid(dst_valid[d]), .data(ddata[d]), .want(want[d])
    );
  end

  xbar_ready u_ready (
    .want(want), .dst_ready(dst_ready), .src_f(src_f),
    .tx_link(tx_link), .src_ready(src_ready)
  );

  xbar_clk u_clk (.src_f(src_f), .clk_sel(src_clk_sel));
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [1:0]      cfg_addr,
  input logic [7:0]      cfg_wdata,
  input logic [15:0]     src_word,
  input logic [15:0]     dst_word,
  input logic [3:0]      src_ready,
  input logic [3:0]      dst_valid,
  input logic [4*DW-1:0] dst_data,
  input logic [3:0]      dst_ready,
  input logic            dsp_rx_oe,
  input logic [7:0]      src_clk_sel
);
  assert_src_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 2'd0 |=> src_word[7:0] == $past(cfg_wdata));
  assert_dst_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 2'd3 |=> dst_word[15:8] == $past(cfg_wdata));
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(dst_word) && $stable(src_word));
  assert_full_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&dst_ready) && src_word[7] |-> (&src_ready));
  assert_tx_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_word[7] |-> !src_ready[1]);
  assert_rx_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_rx_oe |-> !dst_valid[1] && dst_data[DW +: DW] == '0);
  assert_no_undef_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    src_clk_sel[1:0] != 2'b11 && src_clk_sel[3:2] != 2'b11 &&
    src_clk_sel[5:4] != 2'b11 && src_clk_sel[7:6] != 2'b11);
  assert_adc_no_32m_R9: assert property (@(posedge clk) disable iff (!rst_n)
    src_clk_sel[7:6] != 2'b10);
endmodule

bind audio_xbar xbar_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .src_word(src_word), .dst_word(dst_word),
  .src_ready(src_ready), .dst_valid(dst_valid), .dst_data(dst_data),
  .dst_ready(dst_ready), .dsp_rx_oe(dsp_rx_oe), .src_clk_sel(src_clk_sel)
);

// File: tb/sim_audio_xbar.sv
`timescale 1ns/1ps
module sim_audio_xbar;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] src_valid = '0, src_stb = '0, dst_ready = '0;
  logic [4*DW-1:0] src_data = '0;
  logic [3:0] src_ready, dst_valid;
  logic [4*DW-1:0] dst_data;
  logic dsp_rx_oe;
  logic [7:0] src_clk_sel;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  audio_xbar #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_valid(src_valid), .src_stb(src_stb),
    .src_data(src_data), .src_ready(src_ready), .dst_valid(dst_valid),
    .dst_data(dst_data), .dst_ready(dst_ready), .dsp_rx_oe(dsp_rx_oe),
    .src_clk_sel(src_clk_sel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] dd(input int d);
    return dst_data[d*DW +: DW];
  endfunction

  task automatic t_reset;
    src_data = {16'h4444, 16'h3333, 16'h2222, 16'hA5A5};
    src_valid = 4'b0001; dst_ready = 4'b1111;
    #1;
    chk("R1 oe", dsp_rx_oe, 0);
    chk("R1 clk", src_clk_sel, 0);
    chk("R1 valid", dst_valid, 4'b1101);
    chk("R1 data0", dd(0), 16'hA5A5);
    chk("R1 data1", dd(1), 0);
    chk("R1 data3", dd(3), 16'hA5A5);
    chk("R1 ready", src_ready, 4'b1101);
  endtask

  task automatic t_route_hs;
    wr(2, 8'hE4); wr(3, 8'h06);
    src_valid = 4'b1000; #1;
    chk("R3 valid", dst_valid, 4'b0110);
    chk("R3 data0", dd(0), 16'h3333);
    chk("R3 data1", dd(1), 16'h4444);
    chk("R3 data2", dd(2), 16'h4444);
    chk("R3 data3", dd(3), 16'hA5A5);
    chk("R2 oe", dsp_rx_oe, 1);
  endtask

  task automatic t_fanout;
    dst_ready = 4'b1111; #1;
    chk("R5 all", src_ready[3], 1);
    dst_ready = 4'b1011; #1;
    chk("R5 d2 low", src_ready[3], 0);
    dst_ready = 4'b1101; #1;
    chk("R5 d1 low", src_ready[3], 0);
    dst_ready = 4'b0111; #1;
    chk("R5 d3 low", src_ready, 4'b1100);
  endtask

  task automatic t_nohs;
    wr(2, 8'hE5);
    src_valid = 4'b0000; src_stb = 4'b0100; dst_ready = 4'b1110; #1;
    chk("R4 stb", dst_valid[0], 1);
    chk("R4 ready ignored", src_ready[2], 1);
    src_valid = 4'b0100; src_stb = 4'b0000; #1;
    chk("R4 valid ignored", dst_valid[0], 0);
  endtask

  task automatic t_src_hs;
    wr(1, 8'h10);
    dst_ready = 4'b0000; src_stb = 0; #1;
    chk("R6 forced", src_ready[3], 1);
    chk("R6 other", src_ready[0], 0);
    wr(1, 8'h00);
  endtask

  task automatic t_dsp_tx;
    wr(3, 8'h02);
    src_valid = 4'b0010; src_data[DW +: DW] = 16'h1234; dst_ready = 4'b1111; #1;
    chk("R7 valid", dst_valid[2], 0);
    chk("R7 data", dd(2), 0);
    chk("R7 ready", src_ready[1], 0);
    wr(0, 8'h80);
    dst_ready = 4'b1011; #1;
    chk("R7 linked valid", dst_valid[2], 1);
    chk("R7 linked data", dd(2), 16'h1234);
    chk("R5 linked ready", src_ready[1], 0);
  endtask

  task automatic t_dsp_rx;
    wr(2, 8'h65);
    src_valid = 4'b1000; dst_ready = 4'b1101; #1;
    chk("R8 oe", dsp_rx_oe, 0);
    chk("R8 valid", dst_valid[1], 0);
    chk("R8 data", dd(1), 0);
    chk("R8 ready excluded", src_ready[3], 1);
  endtask

  task automatic t_clk;
    wr(0, 8'hC2); wr(1, 8'h46); #1;
    chk("R9 map", src_clk_sel, 8'h09);
    wr(1, 8'h26); #1;
    chk("R9 adc ext", src_clk_sel, 8'h49);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_reroute;
    wr(3, 8'h00);
    src_valid = 4'b0101; src_data[15:0] = 16'h1111; src_data[47:32] = 16'h2222;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h40; #1;
    chk("R2 before edge", dd(3), 16'h1111);
    @(negedge clk);
    cfg_we = 1'b0; #1;
    chk("R2 after edge", dd(3), 16'h2222);
    chk("R3 after edge", dst_valid[3], 1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route_hs();
    t_fanout();
    t_nohs();
    t_src_hs();
    t_dsp_tx();
    t_dsp_rx();
    t_clk();
    t_reroute();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule